// File: doc/BRIEF.md
# Bridge Gate Non-Overlap and Override Stage

This block sits between the commutation logic and the six gate drive outputs of a three-phase bridge. For every phase it takes a high-side and a low-side turn-on request and produces registered gate enables. Whenever a gate of a phase switches off, both gates of that phase are held off for a programmable number of clock cycles before either may switch on again. This keeps the upper and lower switches of a leg from conducting together, including when the rotation direction is reversed while the motor turns.

On top of the normal requests, the block applies forced modes with a fixed priority. Reset outranks everything. Standby, undervoltage and a latched lock fault each force every gate off. Short brake turns every high side off and every low side on. Plain requests come last. The brake low-side turn-on is routed through the same non-overlap timing as normal requests. A high side that was on therefore passes through the full off gap before its low side is enabled.

Each phase runs a four-state machine: IDLE (both off, gap satisfied), DEAD (both off, gap running), HIGH and LOW. The transitions are: IDLE to HIGH or LOW on a request; HIGH or LOW to DEAD when the request goes away or changes; DEAD to HIGH, LOW or IDLE once the gap has run out, chosen by the command in force at that point. The gap is `DEAD_CYC` cycles. At the default of 160 cycles and a 50 MHz clock it is 3.2 µs.

Top module: `gate_guard`

## Requirements
- R1: While reset is asserted, every gate output is low regardless of the inputs.
- R2: The high-side and low-side outputs of the same phase are never high in the same cycle.
- R3: After any gate output of a phase falls, both outputs of that phase stay low for DEAD_CYC clock cycles. The earliest turn-on comes DEAD_CYC edges after the edge that turned the gate off.
- R4: Bit p of each request and output vector belongs to phase p, and phases are independent. In normal mode, a phase at rest (both off, gap elapsed) turns on the requested gate at the first clock edge that samples the request, and keeps it on while the request is held.
- R5: A phase whose high and low requests are both set is treated as fully off and drives both gates low from the next edge.
- R6: When standby, undervoltage or lock fault is high, every gate output is low after the next clock edge. Once the flag clears after the gap has elapsed, requested gates turn on at the next edge.
- R7: With short brake active and no protection flag, every high side is low after the next edge. Each low side turns on at the next edge if its phase was at rest, stays on if already on, and turns on DEAD_CYC edges after its high side fell otherwise.
- R8: Standby, undervoltage and lock fault take precedence over short brake: with both present, all gates are off.
- R9: Short brake takes precedence over the gate requests. High-side requests have no effect on the outputs while braking.
- R10: A direct change of a phase request from high side to low side (or back) gives exactly DEAD_CYC cycles with both gates off between the fall of one gate and the rise of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_hi | input | NPH | High-side turn-on request per phase |
| req_lo | input | NPH | Low-side turn-on request per phase |
| brake | input | 1 | Short brake: all low sides on, all high sides off |
| standby | input | 1 | Standby: all gates off |
| uv_flag | input | 1 | Undervoltage present: all gates off |
| lock_flt | input | 1 | Latched motor lock fault: all gates off |
| gate_hi | output | NPH | Registered high-side gate enable per phase |
| gate_lo | output | NPH | Registered low-side gate enable per phase |

## Verification
The bench builds the block with NPH = 3 and DEAD_CYC = 4. With a gap that short, every cycle of the off window can be sampled one by one, and the exact turn-on edge can be checked against arithmetic from the requirements. In that configuration it sweeps all sixteen pairs of previous and next request codes on each of the three phases, in turn. It then drives each forced mode, their combinations, and a mix of phase states under brake.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    // Resolved operating mode of the whole bridge.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_SAFE  = 2'd2
    } drive_mode_e;

    // Per-phase gate command after override resolution.
    typedef enum logic [1:0] {
        CMD_OFF = 2'd0,
        CMD_HI  = 2'd1,
        CMD_LO  = 2'd2
    } gate_cmd_e;

    // Per-phase non-overlap state.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DEAD = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } phase_state_e;

    // Counter width that holds values 0 .. n-1, at least one bit.
    function automatic int unsigned gap_cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gg_mode_sel.sv
module gg_mode_sel
    import gate_guard_pkg::*;
(
    input  logic        brake,
    input  logic        standby,
    input  logic        uv_flag,
    input  logic        lock_flt,
    output drive_mode_e mode
);

    logic safe_req;

    assign safe_req = standby | uv_flag | lock_flt;

    // Fixed priority: protection, then brake, then normal requests.
    always_comb begin
        if (safe_req) begin
            mode = MODE_SAFE;
        end else if (brake) begin
            mode = MODE_BRAKE;
        end else begin
            mode = MODE_RUN;
        end
    end

endmodule

// File: rtl/gg_cmd_map.sv
module gg_cmd_map
    import gate_guard_pkg::*;
(
    input  drive_mode_e mode,
    input  logic        want_hi,
    input  logic        want_lo,
    output gate_cmd_e   cmd
);

    always_comb begin
        cmd = CMD_OFF;
        unique case (mode)
            MODE_SAFE:  cmd = CMD_OFF;
            MODE_BRAKE: cmd = CMD_LO;
            MODE_RUN: begin
                unique case ({want_hi, want_lo})
                    2'b10:   cmd = CMD_HI;
                    2'b01:   cmd = CMD_LO;
                    default: cmd = CMD_OFF;   // none, or both: both off
                endcase
            end
            default:    cmd = CMD_OFF;
        endcase
    end

endmodule

// File: rtl/gg_phase_fsm.sv
module gg_phase_fsm
    import gate_guard_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 160
)(
    input  logic      clk,
    input  logic      rst_n,
    input  gate_cmd_e cmd,
    output logic      gate_hi,
    output logic      gate_lo
);

    localparam int unsigned CNT_W = gap_cnt_width(DEAD_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC - 1);

    phase_state_e     state_q, state_d;
    logic [CNT_W-1:0] gap_q, gap_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            PH_IDLE: begin
                unique case (cmd)
                    CMD_HI:  state_d = PH_HIGH;
                    CMD_LO:  state_d = PH_LOW;
                    default: state_d = PH_IDLE;
                endcase
            end
            PH_HIGH: begin
                if (cmd != CMD_HI) begin
                    state_d = PH_DEAD;
                    gap_d   = CNT_LOAD;
                end
            end
            PH_LOW: begin
                if (cmd != CMD_LO) begin
                    state_d = PH_DEAD;
                    gap_d   = CNT_LOAD;
                end
            end
            PH_DEAD: begin
                if (gap_q == '0) begin
                    unique case (cmd)
                        CMD_HI:  state_d = PH_HIGH;
                        CMD_LO:  state_d = PH_LOW;
                        default: state_d = PH_IDLE;
                    endcase
                end else begin
                    gap_d = gap_q - 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Registered gate enables, taken from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (state_d == PH_HIGH);
            gate_lo <= (state_d == PH_LOW);
        end
    end

endmodule

// File: rtl/gate_guard.sv
module gate_guard
    import gate_guard_pkg::*;
#(
    parameter int unsigned NPH      = 3,
    parameter int unsigned DEAD_CYC = 160
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] req_hi,
    input  logic [NPH-1:0] req_lo,
    input  logic           brake,
    input  logic           standby,
    input  logic           uv_flag,
    input  logic           lock_flt,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo
);

    drive_mode_e mode;

    gg_mode_sel u_mode (
        .brake    (brake),
        .standby  (standby),
        .uv_flag  (uv_flag),
        .lock_flt (lock_flt),
        .mode     (mode)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        gate_cmd_e cmd;

        gg_cmd_map u_map (
            .mode    (mode),
            .want_hi (req_hi[p]),
            .want_lo (req_lo[p]),
            .cmd     (cmd)
        );

        gg_phase_fsm #(
            .DEAD_CYC (DEAD_CYC)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end

endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk #(
    parameter int unsigned NPH      = 3,
    parameter int unsigned DEAD_CYC = 160
)(
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] req_hi,
    input logic [NPH-1:0] req_lo,
    input logic           brake,
    input logic           standby,
    input logic           uv_flag,
    input logic           lock_flt,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo
);

    localparam int unsigned QW = $clog2(DEAD_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(DEAD_CYC);

    logic prot;
    assign prot = standby | uv_flag | lock_flt;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R6
    safe_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> (gate_hi == '0 && gate_lo == '0));

    // R9
    brake_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && !prot) |=> (gate_hi == '0));

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        logic [QW-1:0] quiet;   // cycles seen with both gates of phase i off

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                quiet <= QMAX;
            end else if (gate_hi[i] || gate_lo[i]) begin
                quiet <= '0;
            end else if (quiet != QMAX) begin
                quiet <= quiet + 1'b1;
            end
        end

        // R3
        dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((gate_hi[i] || gate_lo[i]) && !$past(gate_hi[i] || gate_lo[i]))
            |-> (quiet >= QMAX));

        // R5
        both_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!prot && !brake && req_hi[i] && req_lo[i])
            |=> (!gate_hi[i] && !gate_lo[i]));

        // R7
        brake_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (brake && !prot && gate_lo[i]) |=> gate_lo[i]);
    end

endmodule

bind gate_guard gate_guard_chk #(
    .NPH      (NPH),
    .DEAD_CYC (DEAD_CYC)
) u_gate_guard_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_hi   (req_hi),
    .req_lo   (req_lo),
    .brake    (brake),
    .standby  (standby),
    .uv_flag  (uv_flag),
    .lock_flt (lock_flt),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/test_gate_guard.sv
module test_gate_guard;

    localparam int CLK_NS = 10;
    localparam int NPH    = 3;
    localparam int D      = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] req_hi = '0;
    logic [NPH-1:0] req_lo = '0;
    logic           brake = 1'b0;
    logic           standby = 1'b0;
    logic           uv_flag = 1'b0;
    logic           lock_flt = 1'b0;
    logic [NPH-1:0] gate_hi;
    logic [NPH-1:0] gate_lo;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gate_guard #(.NPH(NPH), .DEAD_CYC(D)) i_gate_guard (
        .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
        .brake(brake), .standby(standby), .uv_flag(uv_flag), .lock_flt(lock_flt),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic check(input string tag, input logic [NPH-1:0] eh, input logic [NPH-1:0] el);
        total++;
        if (gate_hi !== eh || gate_lo !== el) begin
            bad++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    // code: 0 none, 1 high, 2 low, 3 both
    task automatic set_phase(input int p, input int code);
        @(negedge clk);
        req_hi = '0;
        req_lo = '0;
        req_hi[p] = code[0];
        req_lo[p] = code[1];
    endtask

    function automatic int on_gate(input int code);
        return (code == 3) ? 0 : code;
    endfunction

    function automatic logic [NPH-1:0] one_bit(input int p, input bit v);
        logic [NPH-1:0] r = '0;
        r[p] = v;
        return r;
    endfunction

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low even with requests present
        req_hi = '1;
        brake  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", '0, '0);
        rst_n = 1'b1;
        edge_wait();
        check("R4 first request after reset", '1, '0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        req_hi = '0;
        repeat (D + 2) @(posedge clk);

        // R3 R4 R5 R10: every previous/next request pair on each phase
        for (int p = 0; p < NPH; p++) begin
            for (int f = 0; f < 4; f++) begin
                for (int t = 0; t < 4; t++) begin
                    int a;
                    int b;
                    a = on_gate(f);
                    b = on_gate(t);
                    set_phase(p, f);
                    repeat (D + 3) @(posedge clk);
                    #1;
                    check("R4 steady", one_bit(p, a == 1), one_bit(p, a == 2));
                    set_phase(p, t);
                    for (int k = 0; k < D + 3; k++) begin
                        int g;
                        string tag;
                        edge_wait();
                        if (a == b)       g = a;
                        else if (a == 0)  g = b;
                        else if (b == 0)  g = 0;
                        else              g = (k >= D) ? b : 0;
                        if (t == 3)                      tag = "R5 both requested";
                        else if (a != 0 && b != 0 && a != b) tag = "R10 reversal";
                        else if (a != 0 && b == 0)       tag = "R3 off gap";
                        else                             tag = "R4 follow";
                        check(tag, one_bit(p, g == 1), one_bit(p, g == 2));
                    end
                end
            end
        end

        // R3: short off pulse then the other gate
        set_phase(0, 1);
        repeat (D + 3) @(posedge clk);
        set_phase(0, 0);
        edge_wait();
        check("R3 fall", '0, '0);
        set_phase(0, 2);
        for (int k = 1; k <= D + 1; k++) begin
            if (k > 1) edge_wait();
            else #1;
            if (k < D) check("R3 gap held", '0, '0);
            else if (k == D) ;
            else check("R3 after gap", '0, 3'b001);
        end
        set_phase(0, 0);
        repeat (D + 3) @(posedge clk);

        // R6: each protection flag forces all off, then recovery
        for (int fl = 0; fl < 3; fl++) begin
            @(negedge clk);
            req_hi = '1;
            req_lo = '0;
            repeat (D + 3) @(posedge clk);
            #1;
            check("R6 before flag", '1, '0);
            @(negedge clk);
            standby  = (fl == 0);
            uv_flag  = (fl == 1);
            lock_flt = (fl == 2);
            for (int k = 0; k < D + 2; k++) begin
                edge_wait();
                check("R6 flag all off", '0, '0);
            end
            @(negedge clk);
            standby = 1'b0; uv_flag = 1'b0; lock_flt = 1'b0;
            edge_wait();
            check("R6 recovery", '1, '0);
        end

        // R7 R9: brake from mixed phase states (p0 high, p1 low, p2 idle)
        @(negedge clk);
        req_hi = 3'b001;
        req_lo = 3'b010;
        repeat (D + 3) @(posedge clk);
        #1;
        check("R4 mixed steady", 3'b001, 3'b010);
        @(negedge clk);
        brake = 1'b1;
        for (int k = 0; k < D + 3; k++) begin
            edge_wait();
            check("R7 R9 brake", '0, (k >= D) ? 3'b111 : 3'b110);
        end
        @(negedge clk);
        req_hi = '1;
        req_lo = '0;
        for (int k = 0; k < D + 2; k++) begin
            edge_wait();
            check("R9 high request ignored in brake", '0, '1);
        end

        // R8: protection over brake
        @(negedge clk);
        uv_flag = 1'b1;
        for (int k = 0; k < D + 2; k++) begin
            edge_wait();
            check("R8 undervoltage over brake", '0, '0);
        end
        @(negedge clk);
        uv_flag = 1'b0;
        lock_flt = 1'b1;
        edge_wait();
        check("R8 lock over brake", '0, '0);
        @(negedge clk);
        lock_flt = 1'b0;
        edge_wait();
        check("R7 brake from rest", '0, '1);
        @(negedge clk);
        brake = 1'b0;
        req_hi = '0;
        repeat (D + 2) @(posedge clk);
        #1;
        check("R3 idle after brake", '0, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule